// File: doc/BRIEF.md
# I2C Synthesiser Control Slave

This block is the serial control port of a frequency synthesiser. It listens to an I2C bus, oversampled by the system clock, and answers to a 7-bit device address. The two low address bits come from a strap input, so several synthesisers can share one bus. In a write transfer, each data byte's most significant bit decides whether the byte opens a frequency pair or a control pair. The byte after it completes that pair. Any number of pairs may follow before the STOP.

The 15-bit divider word reaches the output in one step. This happens either when its low byte arrives, or at a STOP that follows a lone high byte. The control fields take effect as soon as their byte completes. In a read transfer the block returns a status byte that holds the lock flag and a power-on flag. The status byte repeats for as long as the master acknowledges it. A missing acknowledge ends the read.

The block drives SDA through an open-drain enable, where 1 pulls the line low. Its outputs feed the divider, the reference divider select, the charge pump, the reference output mux, the test logic and four port sinks.

Top module: `syn_ctl_i2c`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1,1,0,0,0 followed by strap_addr[1], strap_addr[0]. Bit 0 is the direction (0 write, 1 read). Any other address gets no acknowledge, and the data bytes that follow it change no output.
- R2: In a write transfer to a matched address, the block pulls SDA low in the acknowledge slot of every complete data byte. It changes its SDA drive only while SCL is low.
- R3: The first data byte of a pair is a frequency byte when its bit 7 is 0 and a control byte when its bit 7 is 1. The next byte is the second byte of the same kind. Further pairs follow the same rule within one transfer.
- R4: The first control byte sets test_ctl = bits 6:4 and ref_ratio = bits 3:0. The second control byte sets cp_code = bits 7:6, refout_en = bit 5, refout_sel = bit 4 and port_on = bits 3:0. Each byte's fields update as soon as that byte completes.
- R5: A first frequency byte (bits 6:0 = word bits 14:8) leaves freq_word unchanged. The second frequency byte (word bits 7:0) updates all 15 bits of freq_word at once.
- R6: A STOP that follows a lone first frequency byte loads its seven bits into freq_word[14:8] and keeps freq_word[7:0].
- R7: A STOP in the middle of a byte discards that partial byte. The outputs keep the values set by earlier complete bytes.
- R8: A read returns the status byte MSB first, with bit 2 = lock_i, bit 1 = power-on flag and all other bits 0.
- R9: When the master acknowledges a status byte, another status byte follows. When the master does not acknowledge, the block releases SDA and drives nothing more until the next START.
- R10: The power-on flag is 1 after reset and after any supply_drop_i pulse. It clears at a bus STOP that ends a transfer containing a read address.
- R11: After reset, freq_word, ref_ratio, cp_code, test_ctl and port_on are 0 (all port sinks off). refout_en and refout_sel are 1, and sda_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_addr | input | 2 | Variable low address bits |
| lock_i | input | 1 | Loop lock indication |
| supply_drop_i | input | 1 | Pulse that sets the power-on flag |
| freq_word | output | 15 | Committed divider word |
| ref_ratio | output | 4 | Reference divider select |
| cp_code | output | 2 | Charge pump current code |
| refout_en | output | 1 | Reference output enable |
| refout_sel | output | 1 | Reference output source select |
| test_ctl | output | 3 | Test mode bits |
| port_on | output | 4 | Port sink states, 1 = sinking |

## Verification
The assertions assume the bus is legal and slow compared with clk. Each SCL phase must last several clocks longer than the input synchroniser. SDA may change only while SCL is low, except for the START and STOP edges. The assertion that the slave changes SDA only while SCL is low relies on this. So do the checks that the outputs move only after a completed byte or a STOP. The stimulus meets these assumptions: it holds every bus phase for four clocks, sets data only in the low phase of SCL, and never lets master and slave drive low in the same slot.

// File: rtl/syn_pkg.sv
package syn_pkg;
    localparam int FREQ_W   = 15;
    localparam int FHI_W    = FREQ_W - 8;
    localparam int RATIO_W  = 4;
    localparam int TEST_W   = 3;
    localparam int CP_W     = 2;
    localparam int PORT_W   = 4;
    localparam int STRAP_W  = 2;
    localparam int ID_W     = 7 - STRAP_W;
    localparam logic [ID_W-1:0] DEV_ID = 5'b11000;

    typedef enum logic [2:0] {
        BS_IDLE, BS_RX, BS_PRE_ACK, BS_ACK, BS_TX, BS_TX_ACK, BS_TX_LOAD
    } bus_state_t;

    typedef struct packed {
        logic [TEST_W-1:0]  test;
        logic [RATIO_W-1:0] ratio;
        logic [CP_W-1:0]    cp;
        logic               ref_en;
        logic               ref_comp;
        logic [PORT_W-1:0]  ports;
    } ctrl_t;

    function automatic logic [7:0] status_byte(input logic lock, input logic por);
        return {5'b00000, lock, por, 1'b0};
    endfunction
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_q     = scl_sh[STAGES-1];
    assign sda_q     = sda_sh[STAGES-1];
    assign scl_rise  = scl_q & ~scl_d;
    assign scl_fall  = ~scl_q & scl_d;
    assign start_det = scl_q & scl_d & sda_d & ~sda_q;
    assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import syn_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_q,
    input  logic               sda_q,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap,
    input  logic [7:0]         tx_byte,
    output logic               sda_oe,
    output logic               byte_stb,
    output logic [7:0]         byte_data,
    output logic               addr_ok,
    output logic               addr_rd
);
    bus_state_t st;
    logic [2:0] cnt;
    logic [7:0] sh;
    logic       is_addr;
    logic       rd;
    logic [7:0] nxt;

    assign nxt = {sh[6:0], sda_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= BS_IDLE;
            cnt      <= '0;
            sh       <= '0;
            is_addr  <= 1'b0;
            rd       <= 1'b0;
            byte_stb <= 1'b0;
            addr_ok  <= 1'b0;
            addr_rd  <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            addr_ok  <= 1'b0;
            addr_rd  <= 1'b0;
            if (start_det) begin
                st      <= BS_RX;
                cnt     <= '0;
                is_addr <= 1'b1;
            end else if (stop_det) begin
                st <= BS_IDLE;
            end else begin
                case (st)
                    BS_RX: if (scl_rise) begin
                        sh  <= nxt;
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            if (is_addr) begin
                                if (nxt[7:1] == {DEV_ID, strap}) begin
                                    st      <= BS_PRE_ACK;
                                    rd      <= nxt[0];
                                    addr_ok <= 1'b1;
                                    addr_rd <= nxt[0];
                                end else begin
                                    st <= BS_IDLE;
                                end
                            end else begin
                                byte_stb <= 1'b1;
                                st       <= BS_PRE_ACK;
                            end
                        end
                    end
                    BS_PRE_ACK: if (scl_fall) st <= BS_ACK;
                    BS_ACK: if (scl_fall) begin
                        is_addr <= 1'b0;
                        cnt     <= '0;
                        if (rd) begin
                            st <= BS_TX;
                            sh <= tx_byte;
                        end else begin
                            st <= BS_RX;
                        end
                    end
                    BS_TX: if (scl_fall) begin
                        sh  <= {sh[6:0], 1'b0};
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) st <= BS_TX_ACK;
                    end
                    BS_TX_ACK: if (scl_rise) st <= sda_q ? BS_IDLE : BS_TX_LOAD;
                    BS_TX_LOAD: if (scl_fall) begin
                        st  <= BS_TX;
                        sh  <= tx_byte;
                        cnt <= '0;
                    end
                    default: st <= BS_IDLE;
                endcase
            end
        end
    end

    assign byte_data = sh;
    assign sda_oe    = (st == BS_ACK) | ((st == BS_TX) & ~sh[7]);

    p_sda_moves_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_q);
    p_data_only_in_write_r3: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> !rd);
endmodule

// File: rtl/syn_reg_file.sv
module syn_reg_file
    import syn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_stb,
    input  logic [7:0]        byte_data,
    input  logic              addr_ok,
    input  logic              addr_rd,
    input  logic              stop_det,
    input  logic              supply_drop,
    input  logic              lock,
    output logic [FREQ_W-1:0] freq,
    output ctrl_t             ctrl,
    output logic [7:0]        status
);
    logic             second;
    logic             kind;
    logic [FHI_W-1:0] hi_pend;
    logic             hi_valid;
    logic             rd_seen;
    logic             por;

    always_ff @(posedge clk) begin
        if (rst) begin
            freq          <= '0;
            ctrl          <= '0;
            ctrl.ref_en   <= 1'b1;
            ctrl.ref_comp <= 1'b1;
            second        <= 1'b0;
            kind          <= 1'b0;
            hi_pend       <= '0;
            hi_valid      <= 1'b0;
            rd_seen       <= 1'b0;
            por           <= 1'b1;
        end else begin
            if (addr_ok) second <= 1'b0;
            if (addr_rd) rd_seen <= 1'b1;
            if (byte_stb) begin
                if (!second) begin
                    second <= 1'b1;
                    kind   <= byte_data[7];
                    if (byte_data[7]) begin
                        ctrl.test  <= byte_data[6:4];
                        ctrl.ratio <= byte_data[3:0];
                    end else begin
                        hi_pend  <= byte_data[6:0];
                        hi_valid <= 1'b1;
                    end
                end else begin
                    second <= 1'b0;
                    if (kind) begin
                        ctrl.cp       <= byte_data[7:6];
                        ctrl.ref_en   <= byte_data[5];
                        ctrl.ref_comp <= byte_data[4];
                        ctrl.ports    <= byte_data[3:0];
                    end else begin
                        freq     <= {hi_pend, byte_data};
                        hi_valid <= 1'b0;
                    end
                end
            end
            if (stop_det) begin
                if (hi_valid) begin
                    freq     <= {hi_pend, freq[7:0]};
                    hi_valid <= 1'b0;
                end
                if (rd_seen) begin
                    por     <= 1'b0;
                    rd_seen <= 1'b0;
                end
            end
            if (supply_drop) por <= 1'b1;
        end
    end

    assign status = status_byte(lock, por);

    p_freq_moves_on_event_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(freq) |-> $past(byte_stb || stop_det));
    p_ctrl_moves_on_byte_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl) |-> $past(byte_stb));
    p_por_clears_at_stop_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(por) |-> $past(stop_det));
endmodule

// File: rtl/syn_ctl_i2c.sv
module syn_ctl_i2c
    import syn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               lock_i,
    input  logic               supply_drop_i,
    output logic [FREQ_W-1:0]  freq_word,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic [CP_W-1:0]    cp_code,
    output logic               refout_en,
    output logic               refout_sel,
    output logic [TEST_W-1:0]  test_ctl,
    output logic [PORT_W-1:0]  port_on
);
    logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic byte_stb, addr_ok, addr_rd;
    logic [7:0] byte_data, status;
    ctrl_t ctrl;

    i2c_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_byte_fsm u_fsm (
        .clk(clk), .rst(rst), .scl_q(scl_q), .sda_q(sda_q),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .strap(strap_addr), .tx_byte(status), .sda_oe(sda_oe),
        .byte_stb(byte_stb), .byte_data(byte_data),
        .addr_ok(addr_ok), .addr_rd(addr_rd)
    );

    syn_reg_file u_regs (
        .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_data(byte_data),
        .addr_ok(addr_ok), .addr_rd(addr_rd), .stop_det(stop_det),
        .supply_drop(supply_drop_i), .lock(lock_i),
        .freq(freq_word), .ctrl(ctrl), .status(status)
    );

    assign ref_ratio  = ctrl.ratio;
    assign cp_code    = ctrl.cp;
    assign refout_en  = ctrl.ref_en;
    assign refout_sel = ctrl.ref_comp;
    assign test_ctl   = ctrl.test;
    assign port_on    = ctrl.ports;

    p_no_drive_in_reset_r11: assert property (@(posedge clk)
        $past(rst) |-> !sda_oe);
endmodule

// File: tb/sim_syn_ctl_i2c.sv
module sim_syn_ctl_i2c;
    localparam int CLK_NS = 10;
    localparam int Q      = 4;
    localparam int LIMIT  = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] strap = 2'b01;
    logic lock = 1'b1;
    logic drop = 1'b0;
    logic sda_oe, bus_sda;
    logic [14:0] freq_word;
    logic [3:0] ref_ratio, port_on;
    logic [1:0] cp_code;
    logic refout_en, refout_sel;
    logic [2:0] test_ctl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic  q_v[$];
    string q_tag[$];
    event  smp;

    assign bus_sda = sda_m & ~sda_oe;

    always #(CLK_NS/2) clk = ~clk;

    syn_ctl_i2c u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(bus_sda), .sda_oe(sda_oe),
        .strap_addr(strap), .lock_i(lock), .supply_drop_i(drop),
        .freq_word(freq_word), .ref_ratio(ref_ratio), .cp_code(cp_code),
        .refout_en(refout_en), .refout_sel(refout_sel),
        .test_ctl(test_ctl), .port_on(port_on)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
    endtask

    task automatic slot(input logic exp, input string tag);
        sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q);
        q_v.push_back(exp); q_tag.push_back(tag); -> smp;
        hold(Q); scl = 1'b0; hold(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b0; hold(Q); scl = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q); scl = 1'b1; hold(Q); sda_m = 1'b1; hold(2*Q);
    endtask

    task automatic write_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        slot(exp_ack, tag);
    endtask

    task automatic read_byte(input logic [7:0] exp, input logic m_ack, input string tag);
        for (int i = 7; i >= 0; i--) slot(exp[i], tag);
        send_bit(~m_ack);
    endtask

    // scoreboard monitor: compares each sampled bus bit with the queued expectation
    initial begin
        forever begin
            @(smp);
            check(int'(bus_sda), int'(q_v.pop_front()), q_tag.pop_front());
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        hold(5); rst = 1'b0; hold(2);
        // R11 reset state
        check(freq_word, 0, "R11 freq_word");
        check(ref_ratio, 0, "R11 ref_ratio");
        check(cp_code, 0, "R11 cp_code");
        check(test_ctl, 0, "R11 test_ctl");
        check(port_on, 0, "R11 port_on");
        check(refout_en, 1, "R11 refout_en");
        check(refout_sel, 1, "R11 refout_sel");
        check(sda_oe, 0, "R11 sda_oe");

        // R1 wrong address: no ack, data ignored
        bus_start();
        write_byte(8'hC4, 1'b1, "R1 foreign address no ack");
        write_byte(8'hD6, 1'b1, "R1 data after foreign address");
        bus_stop();
        check(test_ctl, 0, "R1 test_ctl untouched");
        check(ref_ratio, 0, "R1 ref_ratio untouched");

        // R2 R3 R4 R5 control pair then frequency pair in one transfer
        bus_start();
        write_byte(8'hC2, 1'b0, "R1 matching address ack");
        write_byte(8'hD6, 1'b0, "R2 ack control byte");
        check(test_ctl, 5, "R4 test_ctl");
        check(ref_ratio, 6, "R4 ref_ratio");
        write_byte(8'hAB, 1'b0, "R2 ack second control byte");
        check(cp_code, 2, "R4 cp_code");
        check(refout_en, 1, "R4 refout_en");
        check(refout_sel, 0, "R4 refout_sel");
        check(port_on, 4'hB, "R4 port_on");
        write_byte(8'h55, 1'b0, "R2 ack frequency byte");
        check(freq_word, 0, "R5 freq held after first byte");
        write_byte(8'h3C, 1'b0, "R2 ack second frequency byte");
        check(freq_word, 15'h553C, "R3 freq after pair");
        bus_stop();

        // R6 lone high byte committed at STOP
        bus_start();
        write_byte(8'hC2, 1'b0, "R1 address ack");
        write_byte(8'h03, 1'b0, "R2 ack");
        check(freq_word, 15'h553C, "R5 freq held before STOP");
        bus_stop();
        check(freq_word, 15'h033C, "R6 STOP commits high byte");

        // R7 STOP inside a byte
        bus_start();
        write_byte(8'hC2, 1'b0, "R1 address ack");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        bus_stop();
        check(test_ctl, 5, "R7 partial control byte discarded");
        check(ref_ratio, 6, "R7 ref_ratio kept");
        bus_start();
        write_byte(8'hC2, 1'b0, "R1 address ack");
        write_byte(8'h12, 1'b0, "R2 ack");
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        check(freq_word, 15'h123C, "R7 partial low byte discarded");

        // R1 other strap value, R4 clearing fields
        strap = 2'b10;
        hold(2);
        bus_start();
        write_byte(8'hC2, 1'b1, "R1 old address now foreign");
        bus_stop();
        bus_start();
        write_byte(8'hC4, 1'b0, "R1 strap 10 address ack");
        write_byte(8'h80, 1'b0, "R2 ack");
        write_byte(8'h00, 1'b0, "R2 ack");
        bus_stop();
        check(test_ctl, 0, "R4 test cleared");
        check(refout_en, 0, "R4 refout_en cleared");
        check(port_on, 0, "R4 ports off");

        // R8 R9 read with ack, then nack
        bus_start();
        write_byte(8'hC5, 1'b0, "R1 read address ack");
        read_byte(8'h06, 1'b1, "R8 status lock and POR");
        read_byte(8'h06, 1'b0, "R9 status repeats after ack");
        for (int i = 0; i < 8; i++) slot(1'b1, "R9 released after nack");
        bus_stop();
        check(sda_oe, 0, "R9 sda idle");

        // R10 POR cleared by STOP ending a read
        bus_start();
        write_byte(8'hC5, 1'b0, "R1 read address ack");
        read_byte(8'h04, 1'b0, "R10 POR cleared");
        bus_stop();

        lock = 1'b0;
        drop = 1'b1; hold(1); drop = 1'b0;
        bus_start();
        write_byte(8'hC5, 1'b0, "R1 read address ack");
        read_byte(8'h02, 1'b0, "R10 POR set by supply drop, R8 unlocked");
        bus_stop();

        hold(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule